// File: doc/BRIEF.md
# Colour Lookup Table with Register Write Port

This block holds the colour palette for an 8-bit indexed frame buffer. It has 256 entries, and each entry holds an 8-bit red, an 8-bit green and an 8-bit blue component. Software loads the palette through a 16-byte window of 32-bit registers. One register selects the entry. A second register takes the colour components one at a time. The first write goes to red, the second to green and the third to blue. After the blue write the selected entry moves on by one, so a whole palette can be streamed in after a single index write.

Each colour byte comes from the most significant byte of the 32-bit write data. The pixel pipeline has its own lookup port. It presents an 8-bit index and gets the 24-bit colour one clock later. Every component write also raises a one-cycle strobe that carries the index of the entry it changed, so a downstream cache can follow palette changes.

Top module: `clut_dac`

## Requirements
- R1: A full-width write at byte offset 0 loads the entry pointer from write data bits [31:24] and sets the component step back to red, even if a colour triple is half written.
- R2: A full-width write at byte offset 4 stores write data bits [31:24] into the component chosen by the step for the pointed entry. Steps go red, then green, then blue. Bits [23:0] of the data are ignored.
- R3: The blue write adds one to the pointer modulo 256 (255 wraps to 0) and sets the step back to red.
- R4: `bus_rdata` is zero for every access.
- R5: After reset, every entry reads 0x000000 except entry 255, which reads 0xFFFFFF. The pointer is 0 and the step is red.
- R6: Writes to byte offsets other than 0 and 4 (1, 8, 12 and the others) change no entry, no pointer and no step.
- R7: A write whose byte enables are not all set is dropped and changes no state.
- R8: `lut_rgb` = {red, green, blue} of the entry at `lut_addr`, one clock after the address is sampled. When a component write and a lookup hit the same entry in the same cycle, the lookup returns the value from before the write.
- R9: One cycle after each accepted component write, `upd_stb` is high for one cycle and `upd_idx` holds the index that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data; the colour or index is in [31:24] |
| bus_rdata | output | 32 | Read data, always zero |
| lut_addr | input | 8 | Pixel lookup index |
| lut_rgb | output | 24 | Looked-up colour {R,G,B}, one cycle later |
| upd_stb | output | 1 | Palette entry changed |
| upd_idx | output | 8 | Index of the changed entry |

## Verification
The hardest case to reach is a component write and a lookup of the same entry in the same clock. The bench points the pointer at an entry whose old value it knows. It then holds `lut_addr` on that entry while it issues the red write. It expects the old colour after that edge and the new colour after the next one. Pointer wrap and a phase reset in mid-triple are reached the same way. The bench writes the pointer to 255, or writes it again partway through a triple, and reads back the entries affected through the lookup port.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_t;

  localparam int NUM_PLANES = 3;
  localparam int COMP_W     = 8;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int OFF_IDX = 0,
  parameter int OFF_DAT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W/8-1:0]   be,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NUM_PLANES-1:0] wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [COMP_W-1:0]     wr_byte,
  output logic                  upd_stb,
  output logic [IDX_W-1:0]      upd_idx
);
  localparam int BE_W = DATA_W / 8;

  logic             full_wr, idx_hit, dat_hit;
  logic [IDX_W-1:0] ptr;
  phase_t           phase;

  assign full_wr = sel && we && (be == {BE_W{1'b1}});
  assign idx_hit = full_wr && (addr == ADDR_W'(OFF_IDX));
  assign dat_hit = full_wr && (addr == ADDR_W'(OFF_DAT));
  assign wr_idx  = ptr;
  assign wr_byte = wdata[DATA_W-1 -: COMP_W];

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_en
    assign wr_en[p] = dat_hit && (phase == phase_t'(p));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      phase   <= PH_RED;
      upd_stb <= 1'b0;
      upd_idx <= '0;
    end else begin
      upd_stb <= dat_hit;
      if (dat_hit) upd_idx <= ptr;
      if (idx_hit) begin
        ptr   <= wdata[DATA_W-1 -: IDX_W];
        phase <= PH_RED;
      end else if (dat_hit) begin
        case (phase)
          PH_RED:  phase <= PH_GRN;
          PH_GRN:  phase <= PH_BLU;
          default: begin
            phase <= PH_RED;
            ptr   <= ptr + 1'b1;
          end
        endcase
      end
    end
  end

  p_idx_phase_r1: assert property (@(posedge clk) disable iff (rst)
    idx_hit |=> (phase == PH_RED) && (ptr == $past(wdata[DATA_W-1 -: IDX_W])));

  p_phase_legal_r2: assert property (@(posedge clk) disable iff (rst)
    phase != phase_t'(2'd3));

  p_wrap_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (dat_hit && phase == PH_BLU) |=> (ptr == $past(ptr) + 1'b1) && (phase == PH_RED));

  p_partial_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (sel && we && be != {BE_W{1'b1}}) |=> $stable(ptr) && $stable(phase));
endmodule

// File: rtl/clut_plane.sv
module clut_plane #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [COMP_W-1:0] wd,
  input  logic [IDX_W-1:0]  ra,
  output logic [COMP_W-1:0] rd
);
  localparam int DEPTH = 1 << IDX_W;

  logic [COMP_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [COMP_W-1:0] q_mem;
  logic              q_vld, q_top;

  // Storage without reset so it maps onto block RAM; read-first behaviour.
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q_mem <= mem[ra];
  end

  // Per-entry written flags carry the reset image (255 white, others black).
  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      q_vld   <= 1'b0;
      q_top   <= 1'b0;
    end else begin
      if (we) written[wa] <= 1'b1;
      q_vld <= written[ra];
      q_top <= (ra == {IDX_W{1'b1}});
    end
  end

  assign rd = q_vld ? q_mem : {COMP_W{q_top}};
endmodule

// File: rtl/clut_dac.sv
module clut_dac
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_sel,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W/8-1:0]        bus_be,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [IDX_W-1:0]           lut_addr,
  output logic [NUM_PLANES*COMP_W-1:0] lut_rgb,
  output logic                       upd_stb,
  output logic [IDX_W-1:0]           upd_idx
);
  logic [NUM_PLANES-1:0] wr_en;
  logic [IDX_W-1:0]      wr_idx;
  logic [COMP_W-1:0]     wr_byte;

  assign bus_rdata = '0;

  clut_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .be(bus_be), .wdata(bus_wdata), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_byte(wr_byte), .upd_stb(upd_stb), .upd_idx(upd_idx)
  );

  // Plane 0 is red and sits in the top byte of lut_rgb.
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    clut_plane #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_plane (
      .clk(clk), .rst(rst), .we(wr_en[p]), .wa(wr_idx), .wd(wr_byte),
      .ra(lut_addr), .rd(lut_rgb[(NUM_PLANES-1-p)*COMP_W +: COMP_W])
    );
  end

  p_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_be == '1 && bus_addr == ADDR_W'(4)) |=> upd_stb);

  p_strobe_only_r9: assert property (@(posedge clk) disable iff (rst)
    upd_stb |-> $past(bus_sel && bus_we && bus_addr == ADDR_W'(4)));
endmodule

// File: tb/clut_dac_test.sv
module clut_dac_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_sel = 0, bus_we = 0;
  logic [3:0]  bus_addr = 0, bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  lut_addr = 0;
  logic [23:0] lut_rgb;
  logic        upd_stb;
  logic [7:0]  upd_idx;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  clut_dac uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lut_addr(lut_addr), .lut_rgb(lut_rgb), .upd_stb(upd_stb), .upd_idx(upd_idx)
  );

  typedef struct packed {
    logic        look;  // 1 = lookup check, 0 = register write
    logic [3:0]  addr;
    logic [3:0]  be;
    logic [7:0]  d;     // write byte, or lookup index
    logic [23:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VT [NV] = '{
    '{1,0,4'hF,8'h00,24'h000000,5},  // R5 black
    '{1,0,4'hF,8'hFF,24'hFFFFFF,5},  // R5 white 255
    '{0,4,4'hF,8'h11,0,2}, '{0,4,4'hF,8'h22,0,2}, '{0,4,4'hF,8'h33,0,2},
    '{1,0,4'hF,8'h00,24'h112233,2},  // R2 / R5 pointer starts at 0
    '{0,4,4'hF,8'h44,0,3}, '{0,4,4'hF,8'h55,0,3}, '{0,4,4'hF,8'h66,0,3},
    '{1,0,4'hF,8'h01,24'h445566,3},  // R3 auto increment
    '{0,0,4'hF,8'h80,0,1}, '{0,4,4'hF,8'hAA,0,1}, '{0,0,4'hF,8'h80,0,1},
    '{0,4,4'hF,8'hBB,0,1}, '{0,4,4'hF,8'hCC,0,1}, '{0,4,4'hF,8'hDD,0,1},
    '{1,0,4'hF,8'h80,24'hBBCCDD,1},  // R1 step reset
    '{0,0,4'hF,8'hFF,0,3}, '{0,4,4'hF,8'h01,0,3}, '{0,4,4'hF,8'h02,0,3},
    '{0,4,4'hF,8'h03,0,3}, '{0,4,4'hF,8'h04,0,3}, '{0,4,4'hF,8'h05,0,3},
    '{0,4,4'hF,8'h06,0,3},
    '{1,0,4'hF,8'hFF,24'h010203,3},  // R3
    '{1,0,4'hF,8'h00,24'h040506,3},  // R3 wrap to 0
    '{0,0,4'hF,8'h10,0,7}, '{0,4,4'h7,8'h77,0,7}, '{0,8,4'hF,8'h99,0,6},
    '{0,12,4'hF,8'h98,0,6}, '{0,1,4'hF,8'h97,0,6},
    '{0,4,4'hF,8'h20,0,7}, '{0,4,4'hF,8'h21,0,7}, '{0,4,4'hF,8'h22,0,7},
    '{1,0,4'hF,8'h10,24'h202122,7},  // R7 / R6
    '{1,0,4'hF,8'h11,24'h000000,6}   // R6 neighbour untouched
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = {d, 24'h5A5A5A};
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic look(input logic [7:0] i, output logic [23:0] v);
    @(negedge clk);
    lut_addr = i;
    @(posedge clk); #1;
    v = lut_rgb;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R4", bus_rdata, 0);
    check("R9", {31'd0, upd_stb}, 0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].look) begin
        look(VT[i].d, v);
        check($sformatf("R%0d", VT[i].req), {8'd0, v}, {8'd0, VT[i].exp});
      end else begin
        wr(VT[i].addr, VT[i].be, VT[i].d);
      end
    end

    // R4: reads at both offsets return zero
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 4; bus_be = 4'hF;
    @(posedge clk); #1;
    check("R4", bus_rdata, 0);
    @(negedge clk); bus_addr = 0;
    @(posedge clk); #1;
    check("R4", bus_rdata, 0);
    @(negedge clk); bus_sel = 0;

    // R8 / R9: write red of entry 5 while looking it up
    wr(0, 4'hF, 8'h05);
    @(negedge clk);
    lut_addr = 8'h05;
    bus_sel = 1; bus_we = 1; bus_addr = 4; bus_be = 4'hF; bus_wdata = 32'h90000000;
    @(posedge clk); #1;
    check("R8", {8'd0, lut_rgb}, 32'h000000);
    check("R9", {31'd0, upd_stb}, 1);
    check("R9", {24'd0, upd_idx}, 32'h05);
    @(negedge clk); bus_sel = 0; bus_we = 0;
    @(posedge clk); #1;
    check("R8", {8'd0, lut_rgb}, 32'h900000);
    check("R9", {31'd0, upd_stb}, 0);

    // R7: partial write produces no strobe
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4; bus_be = 4'h8; bus_wdata = 32'h12000000;
    @(posedge clk); #1;
    check("R7", {31'd0, upd_stb}, 0);
    @(negedge clk); bus_sel = 0; bus_we = 0;

    // R5: reset restores the palette image and the pointer
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    look(8'h80, v); check("R5", {8'd0, v}, 32'h000000);
    look(8'hFF, v); check("R5", {8'd0, v}, 32'hFFFFFF);
    look(8'h05, v); check("R5", {8'd0, v}, 32'h000000);
    wr(4, 4'hF, 8'hAB); wr(4, 4'hF, 8'hCD); wr(4, 4'hF, 8'hEF);
    look(8'h00, v); check("R5", {8'd0, v}, 32'hABCDEF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule